// File: doc/BRIEF.md
# Interrupt Routing Configuration Register File

This block holds the programmable state of an I/O interrupt router. Software reaches it through two 32-bit locations on a memory-mapped bus: a select location that names an internal register, and a data window that reads or writes the register currently named. Behind the window sit an identification register, a read-only version word, an arbitration word that mirrors the identification, and one 64-bit routing entry per interrupt pin. Each entry is accessed in two 32-bit halves.

Every routing entry is decoded into its fields and driven to the servicing logic as flat per-pin buses. The servicing logic sets an entry's remote-pending bit through a side input. When the window writes an entry whose pin currently has its request bit raised, the block emits a one-cycle re-service pulse for that pin. Delivery, arbitration and destination matching are not part of this block.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every entry reads as 0x00010000 in its low half and 0 in its high half (only the mask bit, bit 16, set). The select location reads 0 and the identification is 0.
- R2: A write to offset 0x00 stores the low 8 bits of the data as the select value, and offset 0x00 reads it back zero-extended. Offset 0x10 is the window. Every other offset reads 0, and writes to it change nothing.
- R3: With select 0x01 the window reads (NPINS-1) in bits 23:16 and the version code 0x11 in bits 7:0, all other bits 0. Window writes with this select are ignored.
- R4: With select 0x00 a window write stores data bits 27:24 as the identification, and the window reads it back in bits 27:24 with all other bits 0. With select 0x02 the window reads the same value, and writes are ignored.
- R5: A select value s of 0x10 or more addresses entry (s-0x10)>>1, with odd s meaning bits 63:32 and even s meaning bits 31:0. The entry fields are driven on the ports as follows: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger 15, mask 16, destination 63:56.
- R6: A window write to the low half of an entry stores the data with bit 14 (remote-pending) forced to 0. A write to the high half leaves bit 14 as it was.
- R7: A window write whose entry index is NPINS or more changes no entry, and such a read returns 0. Select values 0x03 to 0x0F also read 0.
- R8: Writes take effect only when the size is 4 or 8 bytes. Other sizes change no register and raise no re-service pulse.
- R9: One cycle after an accepted window write to entry i, svc_req has bit i high exactly when irr_vec[i] was high in the write cycle. All other bits are 0, and the pulse lasts one cycle. Select writes never raise it.
- R10: A pulse on rirr_set[i] sets entry i's remote-pending bit from the next cycle. The bit is visible on ent_rirr and in window bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_ofs | input | 8 | Byte offset within the block (16-byte aligned) |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_ofs, combinational |
| irr_vec | input | NPINS | Per-pin request bits from the servicing logic |
| rirr_set | input | NPINS | Per-pin set strobe for the remote-pending bit |
| svc_req | output | NPINS | One-cycle re-service request per pin |
| id_out | output | 4 | Current identification value |
| ent_vector | output | NPINS*8 | Vector of each entry |
| ent_dlv | output | NPINS*3 | Delivery mode of each entry |
| ent_dstmode | output | NPINS | Destination mode of each entry |
| ent_pol | output | NPINS | Polarity of each entry |
| ent_rirr | output | NPINS | Remote-pending bit of each entry |
| ent_trig | output | NPINS | Trigger mode of each entry (1 = level) |
| ent_mask | output | NPINS | Mask bit of each entry |
| ent_dest | output | NPINS*8 | Destination of each entry |

## Verification
Reads are combinational, so bus_rdata is sampled 1 ns after the offset is driven on a falling edge, with no clock edge in between. Register writes, the entry field ports and svc_req change on the one rising edge that follows the strobe. The bench therefore checks them at the next falling edge, and it checks svc_req again one falling edge later to confirm the pulse has ended. The internal reset release costs two cycles, so the bench waits three cycles after deasserting rst_n before the first check.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  // bus offsets (low 8 bits of address)
  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  // select codes for the non-table registers
  localparam logic [7:0] SEL_IDENT  = 8'h00;
  localparam logic [7:0] SEL_VERS   = 8'h01;
  localparam logic [7:0] SEL_ARBIT  = 8'h02;
  localparam logic [7:0] SEL_TABLE  = 8'h10;
  localparam logic [7:0] VERS_CODE  = 8'h11;
  // entry field positions
  localparam int F_VEC  = 0;
  localparam int F_DLV  = 8;
  localparam int F_DSTM = 11;
  localparam int F_POL  = 13;
  localparam int F_RIRR = 14;
  localparam int F_TRIG = 15;
  localparam int F_MASK = 16;
  localparam int F_DEST = 56;
  localparam logic [63:0] ENTRY_RST = 64'h1 << F_MASK;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_s_n = stg_q[1];
endmodule

// File: rtl/irq_regs_decode.sv
module irq_regs_decode #(
  parameter int NPINS = 24,
  parameter int SEL_W = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             bus_wr,
  input  logic [7:0]       bus_ofs,
  input  logic [3:0]       bus_size,
  input  logic [SEL_W-1:0] sel_q,
  output logic             is_sel,
  output logic             is_win,
  output logic             ent_ok,
  output logic             ent_hi,
  output logic [IDX_W-1:0] ent_idx,
  output logic             sel_we,
  output logic             id_we,
  output logic [NPINS-1:0] ent_we
);
  import irq_regs_pkg::*;

  localparam logic [SEL_W-1:0] TBL_BASE = SEL_W'(SEL_TABLE);
  localparam logic [SEL_W-2:0] NPINS_S  = (SEL_W-1)'(NPINS);

  logic             size_ok;
  logic             wr_ok;
  logic [SEL_W-1:0] sel_off;
  logic [SEL_W-2:0] full_idx;

  assign size_ok  = (bus_size == 4'd4) || (bus_size == 4'd8);
  assign wr_ok    = bus_wr && size_ok;
  assign is_sel   = (bus_ofs == OFS_SELECT);
  assign is_win   = (bus_ofs == OFS_WINDOW);
  assign sel_off  = sel_q - TBL_BASE;
  assign full_idx = sel_off[SEL_W-1:1];
  assign ent_ok   = (sel_q >= TBL_BASE) && (full_idx < NPINS_S);
  assign ent_hi   = sel_q[0];
  assign ent_idx  = full_idx[IDX_W-1:0];
  assign sel_we   = wr_ok && is_sel;
  assign id_we    = wr_ok && is_win && (sel_q == SEL_W'(SEL_IDENT));

  for (genvar i = 0; i < NPINS; i++) begin : g_we
    assign ent_we[i] = wr_ok && is_win && ent_ok && (ent_idx == IDX_W'(i));
  end
endmodule

// File: rtl/irq_regs_entry.sv
module irq_regs_entry (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  output logic [63:0] q
);
  import irq_regs_pkg::*;

  logic [63:0] nxt;
  logic        en;

  assign en = we || rirr_set;

  always_comb begin
    nxt = q;
    if (we) begin
      if (hi) begin
        nxt[63:32] = wdata;
      end else begin
        nxt[31:0]   = wdata;
        nxt[F_RIRR] = 1'b0;
      end
    end else if (rirr_set) begin
      nxt[F_RIRR] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= ENTRY_RST;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NPINS = 24,
  parameter int SEL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_ofs,
  input  logic [3:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   irr_vec,
  input  logic [NPINS-1:0]   rirr_set,
  output logic [NPINS-1:0]   svc_req,
  output logic [3:0]         id_out,
  output logic [NPINS*8-1:0] ent_vector,
  output logic [NPINS*3-1:0] ent_dlv,
  output logic [NPINS-1:0]   ent_dstmode,
  output logic [NPINS-1:0]   ent_pol,
  output logic [NPINS-1:0]   ent_rirr,
  output logic [NPINS-1:0]   ent_trig,
  output logic [NPINS-1:0]   ent_mask,
  output logic [NPINS*8-1:0] ent_dest
);
  import irq_regs_pkg::*;

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic             rst_s_n;
  logic [SEL_W-1:0] sel_q, sel_nxt;
  logic [3:0]       id_q, id_nxt;
  logic [NPINS-1:0] svc_q, svc_nxt;
  logic             is_sel, is_win, ent_ok, ent_hi, sel_we, id_we;
  logic [IDX_W-1:0] ent_idx;
  logic [NPINS-1:0] ent_we;
  logic [63:0]      ent_q [NPINS];
  logic [31:0]      win_val;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  irq_regs_decode #(.NPINS(NPINS), .SEL_W(SEL_W)) u_dec (
    .bus_wr(bus_wr), .bus_ofs(bus_ofs), .bus_size(bus_size), .sel_q(sel_q),
    .is_sel(is_sel), .is_win(is_win), .ent_ok(ent_ok), .ent_hi(ent_hi),
    .ent_idx(ent_idx), .sel_we(sel_we), .id_we(id_we), .ent_we(ent_we)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    irq_regs_entry u_ent (
      .clk(clk), .rst_n(rst_s_n), .we(ent_we[i]), .hi(ent_hi),
      .wdata(bus_wdata), .rirr_set(rirr_set[i]), .q(ent_q[i])
    );
    assign ent_vector[i*8 +: 8] = ent_q[i][F_VEC +: 8];
    assign ent_dlv[i*3 +: 3]    = ent_q[i][F_DLV +: 3];
    assign ent_dstmode[i]       = ent_q[i][F_DSTM];
    assign ent_pol[i]           = ent_q[i][F_POL];
    assign ent_rirr[i]          = ent_q[i][F_RIRR];
    assign ent_trig[i]          = ent_q[i][F_TRIG];
    assign ent_mask[i]          = ent_q[i][F_MASK];
    assign ent_dest[i*8 +: 8]   = ent_q[i][F_DEST +: 8];
  end

  // next-state
  always_comb begin
    sel_nxt = sel_q;
    id_nxt  = id_q;
    if (sel_we) sel_nxt = bus_wdata[SEL_W-1:0];
    if (id_we)  id_nxt  = bus_wdata[27:24];
    svc_nxt = ent_we & irr_vec;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sel_q <= '0;
      id_q  <= '0;
      svc_q <= '0;
    end else begin
      if (sel_we) sel_q <= sel_nxt;
      if (id_we)  id_q  <= id_nxt;
      svc_q <= svc_nxt;
    end
  end

  // read path
  always_comb begin
    win_val = '0;
    if (sel_q == SEL_W'(SEL_IDENT) || sel_q == SEL_W'(SEL_ARBIT))
      win_val = {4'h0, id_q, 24'h0};
    else if (sel_q == SEL_W'(SEL_VERS))
      win_val = {8'h0, 8'(NPINS - 1), 8'h0, VERS_CODE};
    else if (ent_ok)
      win_val = ent_hi ? ent_q[ent_idx][63:32] : ent_q[ent_idx][31:0];
    bus_rdata = '0;
    if (is_sel)      bus_rdata = 32'(sel_q);
    else if (is_win) bus_rdata = win_val;
  end

  assign svc_req = svc_q;
  assign id_out  = id_q;
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int NPINS = 24,
  parameter int SEL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_ofs,
  input logic [3:0]       bus_size,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] irr_vec,
  input logic [NPINS-1:0] svc_req,
  input logic [NPINS-1:0] ent_rirr,
  input logic [SEL_W-1:0] sel_q
);
  logic size_bad;
  logic lo_wr;
  logic [SEL_W-1:0] tbl_off;

  assign size_bad = !((bus_size == 4'd4) || (bus_size == 4'd8));
  assign tbl_off  = sel_q - SEL_W'(16);
  assign lo_wr    = bus_wr && !size_bad && (bus_ofs == 8'h10) &&
                    (sel_q >= SEL_W'(16)) && !sel_q[0];

  p_other_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ofs != 8'h00 && bus_ofs != 8'h10) |-> bus_rdata == 32'h0);

  p_version_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ofs == 8'h10 && sel_q == SEL_W'(1)) |->
      bus_rdata == {8'h0, 8'(NPINS - 1), 8'h0, 8'h11});

  p_size_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && size_bad) |=> $stable(sel_q));

  p_svc_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_req));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    p_svc_irr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req[i] |-> $past(irr_vec[i]));

    p_lo_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && tbl_off[SEL_W-1:1] == (SEL_W-1)'(i)) |=> !ent_rirr[i]);
  end
endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_ofs(bus_ofs),
  .bus_size(bus_size), .bus_rdata(bus_rdata), .irr_vec(irr_vec),
  .svc_req(svc_req), .ent_rirr(ent_rirr), .sel_q(sel_q)
);

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
  localparam int  NP     = 24;
  localparam time CLK_PD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [7:0]    bus_ofs;
  logic [3:0]    bus_size;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] irr_vec, rirr_set, svc_req;
  logic [3:0]    id_out;
  logic [NP*8-1:0] ent_vector, ent_dest;
  logic [NP*3-1:0] ent_dlv;
  logic [NP-1:0]   ent_dstmode, ent_pol, ent_rirr, ent_trig, ent_mask;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PD/2) clk = ~clk;

  irq_route_regs #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_ofs(bus_ofs),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irr_vec(irr_vec), .rirr_set(rirr_set), .svc_req(svc_req), .id_out(id_out),
    .ent_vector(ent_vector), .ent_dlv(ent_dlv), .ent_dstmode(ent_dstmode),
    .ent_pol(ent_pol), .ent_rirr(ent_rirr), .ent_trig(ent_trig),
    .ent_mask(ent_mask), .ent_dest(ent_dest)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [3:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = ofs; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_ofs = ofs;
    #1ns;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lo_pat(input int i);
    return {8'(i*3), 8'(i+1), 8'(i*5+7), 8'(i*11)};
  endfunction

  function automatic logic [31:0] hi_pat(input int i);
    return {8'(i*13+1), 8'(i), 8'(~i), 8'(i*9)};
  endfunction

  initial begin
    #(CLK_PD*150000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    rst_n = 1'b0; bus_wr = 1'b0; bus_ofs = 8'h00; bus_size = 4'd4;
    bus_wdata = '0; irr_vec = '0; rirr_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 select", 64'(v), 64'h0);
    chk("R1 id port", 64'(id_out), 64'h0);
    chk("R1 mask ports", 64'(ent_mask), 64'((1 << NP) - 1));
    for (int i = 0; i < NP; i++) begin
      wr(8'h00, 4'd4, 32'(16 + 2*i));
      rd(8'h10, v); chk("R1 entry lo", 64'(v), 64'h0001_0000);
      wr(8'h00, 4'd4, 32'(17 + 2*i));
      rd(8'h10, v); chk("R1 entry hi", 64'(v), 64'h0);
    end

    // R2 select location and stray offsets
    wr(8'h00, 4'd4, 32'hFFFF_FF5A);
    rd(8'h00, v); chk("R2 select readback", 64'(v), 64'h5A);
    foreach (v[k]) begin end
    rd(8'h20, v); chk("R2 ofs 0x20", 64'(v), 64'h0);
    rd(8'h04, v); chk("R2 ofs 0x04", 64'(v), 64'h0);
    rd(8'hF0, v); chk("R2 ofs 0xF0", 64'(v), 64'h0);
    wr(8'h30, 4'd4, 32'h0000_0011);
    rd(8'h00, v); chk("R2 stray write", 64'(v), 64'h5A);

    // R3 version
    wr(8'h00, 4'd4, 32'h1);
    e = {8'h0, 8'(NP - 1), 8'h0, 8'h11};
    rd(8'h10, v); chk("R3 version", 64'(v), 64'(e));
    wr(8'h10, 4'd4, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R3 version after write", 64'(v), 64'(e));

    // R4 identification and arbitration mirror
    wr(8'h00, 4'd4, 32'h0);
    wr(8'h10, 4'd4, 32'hA5FF_FFFF);
    rd(8'h10, v); chk("R4 id read", 64'(v), 64'h0500_0000);
    chk("R4 id port", 64'(id_out), 64'h5);
    wr(8'h00, 4'd4, 32'h2);
    rd(8'h10, v); chk("R4 arb mirror", 64'(v), 64'h0500_0000);
    wr(8'h10, 4'd4, 32'h0F00_0000);
    rd(8'h10, v); chk("R4 arb write ignored", 64'(v), 64'h0500_0000);

    // R5 and R6: table sweep, both halves, field ports
    for (int i = 0; i < NP; i++) begin
      wr(8'h00, 4'd4, 32'(16 + 2*i));
      wr(8'h10, 4'd4, lo_pat(i));
      wr(8'h00, 4'd4, 32'(17 + 2*i));
      wr(8'h10, 4'd8, hi_pat(i));
    end
    for (int i = 0; i < NP; i++) begin
      logic [31:0] lo, hi;
      lo = lo_pat(i) & ~32'h4000;
      hi = hi_pat(i);
      wr(8'h00, 4'd4, 32'(16 + 2*i));
      rd(8'h10, v); chk("R5 R6 lo half", 64'(v), 64'(lo));
      wr(8'h00, 4'd4, 32'(17 + 2*i));
      rd(8'h10, v); chk("R5 hi half", 64'(v), 64'(hi));
      chk("R5 field ports",
          {24'h0, ent_dest[i*8 +: 8], ent_vector[i*8 +: 8], 1'b0, ent_dlv[i*3 +: 3],
           ent_dstmode[i], ent_pol[i], ent_rirr[i], ent_trig[i], ent_mask[i]},
          {24'h0, hi[31:24], lo[7:0], 1'b0, lo[10:8],
           lo[11], lo[13], lo[14], lo[15], lo[16]});
    end

    // R10 remote-pending set, R6 high write keeps it, low write clears it
    @(negedge clk); rirr_set = 24'h1 << 3;
    @(negedge clk); rirr_set = '0;
    chk("R10 rirr port", 64'(ent_rirr[3]), 64'h1);
    wr(8'h00, 4'd4, 32'h16);
    rd(8'h10, v); chk("R10 rirr in window", 64'(v), 64'(lo_pat(3) | 32'h4000));
    wr(8'h00, 4'd4, 32'h17);
    wr(8'h10, 4'd4, 32'h1234_5678);
    chk("R6 hi write keeps rirr", 64'(ent_rirr[3]), 64'h1);
    wr(8'h00, 4'd4, 32'h16);
    wr(8'h10, 4'd4, lo_pat(3) | 32'h4000);
    rd(8'h10, v); chk("R6 lo write clears rirr", 64'(v), 64'(lo_pat(3) & ~32'h4000));
    chk("R6 rirr port cleared", 64'(ent_rirr[3]), 64'h0);

    // R7 out-of-range entry and unused select codes
    wr(8'h00, 4'd4, 32'(16 + 2*NP));
    wr(8'h10, 4'd4, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R7 beyond table read", 64'(v), 64'h0);
    wr(8'h00, 4'd4, 32'(14 + 2*NP));
    rd(8'h10, v); chk("R7 last entry intact", 64'(v), 64'(lo_pat(NP-1) & ~32'h4000));
    wr(8'h00, 4'd4, 32'h3);
    rd(8'h10, v); chk("R7 select 0x03 reads 0", 64'(v), 64'h0);

    // R8 sizes
    wr(8'h00, 4'd2, 32'h0000_0020);
    rd(8'h00, v); chk("R8 size 2 dropped", 64'(v), 64'h3);
    wr(8'h00, 4'd1, 32'h0000_0020);
    rd(8'h00, v); chk("R8 size 1 dropped", 64'(v), 64'h3);
    wr(8'h00, 4'd8, 32'h0000_0021);
    rd(8'h00, v); chk("R8 size 8 accepted", 64'(v), 64'h21);

    // R9 re-service pulse
    irr_vec = 24'h1 << 5;
    wr(8'h00, 4'd4, 32'h1A);
    chk("R9 select write no pulse", 64'(svc_req), 64'h0);
    wr(8'h10, 4'd4, lo_pat(5));
    chk("R9 pulse on entry 5", 64'(svc_req), 64'(24'h1 << 5));
    @(negedge clk);
    chk("R9 pulse ends", 64'(svc_req), 64'h0);
    wr(8'h10, 4'd2, lo_pat(5));
    chk("R8 R9 bad size no pulse", 64'(svc_req), 64'h0);
    wr(8'h00, 4'd4, 32'h1C);
    wr(8'h10, 4'd4, lo_pat(6));
    chk("R9 no pulse without request", 64'(svc_req), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule